// File: doc/BRIEF.md
# Three-Valued Output Resolver

This unit merges several requests that all target one physical output into a single Boolean drive. Each request comes from its own control rule. A request can ask for a high output, ask for a low output, or leave the output free ("don't care"). The number of request lanes is a build parameter, set to match the number of rules that constrain the output.

A request is carried on two wires, a valid bit and a value bit. When the valid bit is low, the request is "don't care". Any lane can be built with an inverter. The inverter flips the lane's value when the lane is valid and leaves a free lane free. If only one polarity is requested, the drive follows it. If no lane constrains the output, the drive takes a default level fixed at build time.

When high and low are requested in the same cycle, the rules cannot all be met. The unit raises a conflict flag and drives the default level. A typical use is a pair of interlocked motor outputs that must never both be on. There the default for the opening motor is low. The unit holds no state and has no clock.

Top module: `output_resolver`

## Requirements
- R1: When at least one valid lane asks for high and no valid lane asks for low, `drive_o` is 1.
- R2: When at least one valid lane asks for low and no valid lane asks for high, `drive_o` is 0.
- R3: When every `req_valid_i` bit is 0, `drive_o` equals the parameter `DEFAULT_VAL`.
- R4: `conflict_o` is 1 exactly when one valid lane asks for high and another valid lane asks for low in the same input pattern.
- R5: While `conflict_o` is 1, `drive_o` equals `DEFAULT_VAL`.
- R6: Bit k of the parameter `INV_MASK` set to 1 makes lane k ask for the complement of `req_value_i[k]` when that lane is valid. Lane k asks for high when `req_value_i[k]` differs from `INV_MASK[k]`. A masked lane whose valid bit is 0 stays "don't care".
- R7: The `req_value_i` bit of a lane whose `req_valid_i` bit is 0 has no effect on `drive_o` or `conflict_o`.
- R8: The unit holds no state. Both outputs settle in the same cycle as the inputs they depend on, and the same input pattern gives the same outputs whatever patterns came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid_i | input | N_REQ | Per-lane constraint enable; 0 means "don't care" |
| req_value_i | input | N_REQ | Per-lane requested level, before the optional inversion |
| drive_o | output | 1 | Resolved Boolean drive for the physical output |
| conflict_o | output | 1 | High when both polarities are requested at once |

## Verification
The embedded assertions check four rules on every input change. An output request of one polarity must win (R1, R2). An empty request set must give the default (R3). The conflict flag must match a lane-by-lane count of high and low requests (R4). A conflict must fall back to the default (R5).

The assertions cannot show that one set of parameters behaves differently from another. The bench covers this with two instances that use different defaults and different inverter masks. Only the bench's scenarios show three further points:
- free lanes ignore their value bits (R7);
- masked lanes keep "don't care" (R6);
- a repeated pattern gives the same outputs after a different history (R8).

// File: rtl/output_resolver.sv
module output_resolver #(
  parameter int unsigned           N_REQ       = 3,
  parameter bit                    DEFAULT_VAL = 1'b0,
  parameter logic [N_REQ-1:0]      INV_MASK    = '0
) (
  input  logic [N_REQ-1:0] req_valid_i,
  input  logic [N_REQ-1:0] req_value_i,
  output logic             drive_o,
  output logic             conflict_o
);

  logic [N_REQ-1:0] polar;
  logic [N_REQ-1:0] want_hi;
  logic [N_REQ-1:0] want_lo;
  logic             any_hi;
  logic             any_lo;

  // per-lane optional inverter; a free lane stays free because valid is untouched
  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    if (INV_MASK[g]) begin : g_inv
      assign polar[g] = ~req_value_i[g];
    end else begin : g_pass
      assign polar[g] = req_value_i[g];
    end
  end

  assign want_hi = req_valid_i & polar;
  assign want_lo = req_valid_i & ~polar;
  assign any_hi  = |want_hi;
  assign any_lo  = |want_lo;

  assign conflict_o = any_hi & any_lo;
  assign drive_o    = any_hi ? (any_lo ? DEFAULT_VAL : 1'b1)
                             : (any_lo ? 1'b0 : DEFAULT_VAL);

  always_comb begin : chk
    int unsigned n_hi;
    int unsigned n_lo;
    n_hi = 0;
    n_lo = 0;
    for (int k = 0; k < N_REQ; k++) begin
      if (req_valid_i[k]) begin
        if (req_value_i[k] != INV_MASK[k]) n_hi = n_hi + 1;
        else                               n_lo = n_lo + 1;
      end
    end
    p_high_wins_r1: assert (!(n_hi != 0 && n_lo == 0) || drive_o)
      else $error("R1 high request lost");
    p_low_wins_r2: assert (!(n_lo != 0 && n_hi == 0) || !drive_o)
      else $error("R2 low request lost");
    p_free_default_r3: assert ((n_hi + n_lo) != 0 || drive_o == DEFAULT_VAL)
      else $error("R3 default not driven");
    p_conflict_flag_r4: assert (conflict_o == (n_hi != 0 && n_lo != 0))
      else $error("R4 conflict flag wrong");
    p_conflict_default_r5: assert (!conflict_o || drive_o == DEFAULT_VAL)
      else $error("R5 conflict drive wrong");
  end

endmodule

// File: tb/output_resolver_test.sv
module output_resolver_test;

  localparam int unsigned N = 4;
  localparam logic [N-1:0] MASK_A = 4'b0100;
  localparam logic [N-1:0] MASK_B = 4'b1001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] valid = '0;
  logic [N-1:0] value = '0;
  logic drv_a, cf_a, drv_b, cf_b;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  output_resolver #(.N_REQ(N), .DEFAULT_VAL(1'b0), .INV_MASK(MASK_A)) uut (
    .req_valid_i(valid), .req_value_i(value), .drive_o(drv_a), .conflict_o(cf_a));

  output_resolver #(.N_REQ(N), .DEFAULT_VAL(1'b1), .INV_MASK(MASK_B)) uut_b (
    .req_valid_i(valid), .req_value_i(value), .drive_o(drv_b), .conflict_o(cf_b));

  function automatic logic [1:0] model(input logic [N-1:0] v, input logic [N-1:0] d,
                                       input logic [N-1:0] m, input logic dflt);
    logic hi, lo;
    hi = 1'b0;
    lo = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (v[k]) begin
        if (d[k] ^ m[k]) hi = 1'b1;
        else             lo = 1'b1;
      end
    end
    if (hi && lo)  return {1'b1, dflt};
    if (hi)        return 2'b01;
    if (lo)        return 2'b00;
    return {1'b0, dflt};
  endfunction

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s valid=%b value=%b actual=%b expected=%b", req, what, valid, value, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] v, input logic [N-1:0] d, input string req);
    logic [1:0] ea, eb;
    @(posedge clk);
    valid = v;
    value = d;
    @(negedge clk);
    ea = model(v, d, MASK_A, 1'b0);
    eb = model(v, d, MASK_B, 1'b1);
    check_bit(req, "drive_a", drv_a, ea[0]);
    check_bit(req, "conflict_a", cf_a, ea[1]);
    check_bit(req, "drive_b", drv_b, eb[0]);
    check_bit(req, "conflict_b", cf_b, eb[1]);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] rv, rd;
    string tag;
    logic [1:0] ea;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R3", "reset drive_a", drv_a, 1'b0);
    check_bit("R3", "reset drive_b", drv_b, 1'b1);
    check_bit("R4", "reset conflict_a", cf_a, 1'b0);
    rst = 1'b0;
    apply(4'b0000, 4'b1111, "R7");
    apply(4'b0001, 4'b0001, "R1");
    apply(4'b0011, 4'b0011, "R1");
    apply(4'b0010, 4'b0000, "R2");
    apply(4'b0011, 4'b0001, "R4");
    apply(4'b0011, 4'b0001, "R5");
    apply(4'b0100, 4'b0100, "R6");
    apply(4'b0100, 4'b0000, "R6");
    apply(4'b1011, 4'b0100, "R6");
    apply(4'b0010, 4'b1101, "R7");
    apply(4'b1111, 4'b1011, "R4");
    apply(4'b0001, 4'b0001, "R8");
    apply(4'b1111, 4'b1111, "R8");
    apply(4'b0001, 4'b0001, "R8");
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      rv = N'($urandom);
      rd = N'($urandom);
      ea = model(rv, rd, MASK_A, 1'b0);
      if (rv == '0)      tag = "R3";
      else if (ea[1])    tag = "R5";
      else if (ea[0])    tag = "R1";
      else               tag = "R2";
      apply(rv, rd, tag);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule